// File: doc/BRIEF.md
# Four-Channel Serial DAC Register Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host shifts 11-bit command frames in over three slow pins: a serial clock, a serial data line, and a load strobe. The system clock samples all three pins. Each frame carries a channel address, a range-doubling flag and an 8-bit code.

A low pulse on the load strobe copies the frame's flag and code into the input latch of the addressed channel. Each channel holds two register stages. The second stage drives the converter. A separate update pin moves all four input latches into the output stage in the same cycle. The update pin may also be held low, and then each load reaches its output directly.

The resistor network, the reference and the output amplifier sit outside this block. It presents four 8-bit codes and four range flags to that analog section.

Top module: `quad_dac_frontend`

## Requirements
- R1: After reset, all four codes and all four range flags at the outputs are zero.
- R2: A data bit is taken on each falling edge of the serial clock, most significant bit first. The frame layout is: bits 10:9 are the channel address, bit 8 is the range flag, and bits 7:0 are the code.
- R3: Address 0 selects channel 0, address 1 selects channel 1, address 2 selects channel 2, and address 3 selects channel 3. The channels that are not addressed keep their contents.
- R4: The range flag is stored per channel, beside that channel's code. Flag 0 means a 1x span and flag 1 means a 2x span. It appears on `range_o[ch]`.
- R5: While the update pin stays high, a load changes only the input latch. The outputs keep their values.
- R6: A low pulse on the update pin copies all four input latches to the outputs in the same clock cycle.
- R7: While the update pin is held low, each load pulse changes the addressed channel's output, and nothing further is needed.
- R8: If more than 11 bits are shifted in before a load, only the last 11 bits count.
- R9: Shifting bits with no load pulse leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| load_ni | input | 1 | Load strobe, active low, asynchronous |
| upd_ni | input | 1 | Output update, active low, asynchronous |
| code_o | output | 32 | Output codes, channel n in bits 8n+7:8n |
| range_o | output | 4 | Output range flags, one per channel |

## Verification
Suppose the shift register, the address decode or an input latch holds a wrong value. The outputs do not show it when the load happens. They show it at the next update pulse, or about five system clocks after the load when the update pin is held low. For this reason every scenario ends with a transfer to the outputs and then compares all four channels. A wrong address hits a neighbour channel. The bench reveals this because every channel holds a distinct code. An output stage that leaks through while the update pin is high shows up within a few cycles of the load, before any update pulse.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned NCH_DEF = 4;
  localparam int unsigned DW_DEF  = 8;

  function automatic int unsigned frame_w(int unsigned nch, int unsigned dw);
    return $clog2(nch) + 1 + dw;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 1,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= RST_V[i];
        s2_q[i] <= RST_V[i];
        s3_q[i] <= RST_V[i];
      end else begin
        s1_q[i] <= pin_i[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign fall_o[i] = s3_q[i] & ~s2_q[i];
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [FW-1:0] frame_o
);
  logic [FW-1:0] sh_q;

  // oldest bits fall off the top; last FW bits remain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[FW-2:0], bit_i};
  end

  assign frame_o = sh_q;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sh_q));
  // R2
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sh_q[0] == $past(bit_i));
endmodule

// File: rtl/chan_bank.sv
module chan_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  localparam int unsigned AW = $clog2(NCH),
  localparam int unsigned EW = DW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [EW-1:0]  word_i,
  input  logic           xfer_i,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0] range_o
);
  logic [NCH-1:0] we;
  logic [EW-1:0]  in_q  [NCH];
  logic [EW-1:0]  out_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign we[c] = wr_i && (addr_i == AW'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    in_q[c] <= '0;
      else if (we[c]) in_q[c] <= word_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     out_q[c] <= '0;
      else if (xfer_i) out_q[c] <= in_q[c];
    end

    assign code_o[c*DW +: DW] = out_q[c][DW-1:0];
    assign range_o[c]         = out_q[c][DW];

    // R3
    untouched_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we[c] |=> $stable(in_q[c]));
    // R5
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xfer_i |=> $stable(out_q[c]));
  end

  // R3
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import quad_dac_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned DW  = DW_DEF,
  localparam int unsigned AW = $clog2(NCH),
  localparam int unsigned FW = AW + 1 + DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              load_ni,
  input  logic              upd_ni,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    range_o
);
  // pin order: sclk, sdata, load, upd (load/upd idle high)
  logic [3:0] lvl, fall;
  logic [FW-1:0] frame;

  pin_sync #(.W(4), .RST_V(4'b1100)) u_sync (
    .clk_i, .rst_ni,
    .pin_i  ({upd_ni, load_ni, sdata_i, sclk_i}),
    .lvl_o  (lvl),
    .fall_o (fall)
  );

  frame_shifter #(.FW(FW)) u_shift (
    .clk_i, .rst_ni,
    .shift_i (fall[0]),
    .bit_i   (lvl[1]),
    .frame_o (frame)
  );

  // update held low -> output stage transparent (one cycle behind latch)
  chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk_i, .rst_ni,
    .wr_i    (fall[2]),
    .addr_i  (frame[FW-1 -: AW]),
    .word_i  (frame[DW:0]),
    .xfer_i  (!lvl[3]),
    .code_o,
    .range_o
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (code_o == '0 && range_o == '0) || !rst_ni);
endmodule

// File: tb/sim_quad_dac_frontend.sv
module sim_quad_dac_frontend;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdata = 0, load_n = 1, upd_n = 1;
  logic [NCH*DW-1:0] code;
  logic [NCH-1:0] rng;

  always #2 clk = ~clk;

  quad_dac_frontend u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .load_ni(load_n), .upd_ni(upd_n), .code_o(code), .range_o(rng)
  );

  typedef struct {
    logic [NCH*DW-1:0] code;
    logic [NCH-1:0]    rng;
    string             tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [DW:0] m_in [NCH];
  logic [DW:0] m_out[NCH];
  bit upd_low = 0;
  bit done = 0;

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(string tag);
    item_t it;
    for (int c = 0; c < NCH; c++) begin
      it.code[c*DW +: DW] = m_out[c][DW-1:0];
      it.rng[c]           = m_out[c][DW];
    end
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 1; sdata = v[i];
      wait_clk(3);
      sclk = 0;
      wait_clk(3);
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 0;
    wait_clk(4);
    load_n = 1;
    wait_clk(4);
  endtask

  // frame: addr[10:9] rng[8] code[7:0]
  task automatic write_ch(int ch, bit r, logic [7:0] d, string tag);
    send_bits({21'd0, 2'(ch), r, d}, 11);
    pulse_load();
    m_in[ch] = {r, d};
    if (upd_low) m_out[ch] = m_in[ch];
    push(tag);
  endtask

  task automatic pulse_upd(string tag);
    @(negedge clk); upd_n = 0;
    wait_clk(4);
    upd_n = 1;
    wait_clk(4);
    for (int c = 0; c < NCH; c++) m_out[c] = m_in[c];
    push(tag);
  endtask

  // monitor
  initial begin
    forever begin
      item_t e;
      wait (q.size() > 0);
      wait_clk(12);
      e = q[0];
      checks++;
      if (code !== e.code || rng !== e.rng) begin
        errors++;
        $display("FAIL %s: code=%h rng=%b expected code=%h rng=%b",
                 e.tag, code, rng, e.code, e.rng);
      end
      void'(q.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_in[c] = '0; m_out[c] = '0; end
    wait_clk(3);
    rst_ni = 1;
    push("R1 reset state");

    // R5: latch only, outputs hold
    write_ch(0, 0, 8'h11, "R5 ch0 latch hidden");
    write_ch(1, 1, 8'h22, "R5 ch1 latch hidden");
    write_ch(2, 0, 8'h33, "R5 ch2 latch hidden");
    write_ch(3, 1, 8'h44, "R5 ch3 latch hidden");
    // R6, R3, R4, R2
    pulse_upd("R6 R3 R4 R2 simultaneous update");

    // R9: bits without load
    send_bits(32'h7FF, 11);
    push("R9 shift without load");
    pulse_upd("R9 latches untouched");

    // R8: 14 bits, leading 3 discarded
    send_bits({18'd0, 3'b111, 2'd2, 1'b1, 8'hA5}, 14);
    pulse_load();
    m_in[2] = {1'b1, 8'hA5};
    push("R8 long frame hidden");
    pulse_upd("R8 last 11 bits kept");

    // R7: update held low
    @(negedge clk); upd_n = 0; upd_low = 1;
    write_ch(1, 0, 8'hFF, "R7 direct ch1");
    write_ch(3, 0, 8'h00, "R7 direct ch3 zero");
    write_ch(0, 1, 8'h80, "R7 R4 direct ch0 range");
    write_ch(2, 0, 8'h5A, "R7 R3 direct ch2");
    @(negedge clk); upd_n = 1; upd_low = 0;
    wait_clk(6);

    // R5 again after leaving direct mode
    write_ch(3, 1, 8'hC3, "R5 hold after direct mode");
    pulse_upd("R6 final update");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule